// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block sits beside two clock dividers, group A and group C, which both run from one shared internal clock. Each group's division ratio comes from its own 2-bit select. The block works out how many internal clock cycles pass between moments when the rising edges of both divided clocks line up. That interval is the least common multiple of the two divisors. The block then drives an active-low sync line. The line drops for one internal clock cycle just before each aligned edge, so that downstream logic is warned one cycle ahead.

The block does not look at the divided clocks. It derives the alignment instant from the same counting that the dividers use. The first rising internal clock edge at which reset is low counts as an aligned edge. From there the interval repeats for as long as the selects stay put. Changing a select is expected to go together with a reset of the block and of the dividers.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst` is sampled high at a rising `clk` edge, `sync_n` is 1 after that edge.
- R2: The group A select picks the A divisor: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 12.
- R3: The group C select picks the C divisor: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8.
- R4: The interval P between aligned edges is the least common multiple of the A and C divisors. Successive low pulses on `sync_n` are exactly P cycles apart.
- R5: Number the rising edges from 0, starting at the first one where `rst` is sampled low. Edge 0 is aligned. The first low pulse therefore follows edge P-1, and in general `sync_n` is 0 after edge n exactly when n mod P equals P-1.
- R6: Each low pulse lasts exactly one clock cycle and ends at the aligned edge.
- R7: When the two divisors are equal (A select 0 with C select 1, A 1 with C 2, A 2 with C 3), a pulse occurs once per A divisor period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared internal clock from which both groups divide |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel_a | input | 2 | Group A divisor select (R2 encoding) |
| ratio_sel_c | input | 2 | Group C divisor select (R3 encoding) |
| sync_n | output | 1 | Active-low early-warning pulse before each aligned edge |

## Verification
The counter assertions take the two selects to be steady whenever reset is low. For that reason the bound and wrap properties are qualified on the looked-up interval being stable. The stimulus changes the selects only at a falling edge while `rst` is held high, and it keeps reset high for several cycles each time, so every configuration starts from a clean phase 0. One run pulls reset in the middle of a configuration, to check that the block aligns again from the new edge 0.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;

    localparam int SEL_W   = 2;
    localparam int NUM_SEL = 1 << SEL_W;

    typedef logic [SEL_W-1:0] sel_t;

    function automatic int a_divisor(input int sel);
        case (sel)
            0:       return 4;
            1:       return 6;
            2:       return 8;
            default: return 12;
        endcase
    endfunction

    function automatic int c_divisor(input int sel);
        case (sel)
            0:       return 2;
            1:       return 4;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int gcd_of(input int x, input int y);
        int p;
        int q;
        int t;
        p = x;
        q = y;
        for (int i = 0; i < 32; i++) begin
            if (q != 0) begin
                t = p % q;
                p = q;
                q = t;
            end
        end
        return p;
    endfunction

    function automatic int lcm_of(input int x, input int y);
        return (x / gcd_of(x, y)) * y;
    endfunction

    function automatic int max_period();
        int m;
        m = 1;
        for (int ia = 0; ia < NUM_SEL; ia++) begin
            for (int ic = 0; ic < NUM_SEL; ic++) begin
                if (lcm_of(a_divisor(ia), c_divisor(ic)) > m)
                    m = lcm_of(a_divisor(ia), c_divisor(ic));
            end
        end
        return m;
    endfunction

    localparam int MAX_PERIOD = max_period();
    localparam int CNT_W      = $clog2(MAX_PERIOD);

    typedef logic [CNT_W-1:0] phase_t;

    typedef struct packed {
        phase_t phase;
        logic   next_at_last;
    } ctr_state_t;

endpackage

// File: rtl/coin_sync_period_lut.sv
module coin_sync_period_lut
    import coin_sync_pkg::*;
(
    input  sel_t   sel_a,
    input  sel_t   sel_c,
    output phase_t last_idx
);

    localparam int ENTRIES = NUM_SEL * NUM_SEL;

    phase_t tbl [ENTRIES];

    for (genvar ia = 0; ia < NUM_SEL; ia++) begin : g_a
        for (genvar ic = 0; ic < NUM_SEL; ic++) begin : g_c
            localparam int PERIOD = lcm_of(a_divisor(ia), c_divisor(ic));
            assign tbl[ia*NUM_SEL + ic] = phase_t'(PERIOD - 1);
        end
    end

    assign last_idx = tbl[{sel_a, sel_c}];

endmodule

// File: rtl/coin_sync_phase_ctr.sv
module coin_sync_phase_ctr
    import coin_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_t     last_idx,
    output ctr_state_t st
);

    phase_t phase_q;
    phase_t phase_d;

    always_comb begin
        if (rst)
            phase_d = last_idx;
        else if (phase_q >= last_idx)
            phase_d = '0;
        else
            phase_d = phase_q + phase_t'(1);
    end

    always_ff @(posedge clk) begin
        phase_q <= phase_d;
    end

    assign st.phase        = phase_q;
    assign st.next_at_last = (phase_d == last_idx);

    // R4: phase never passes the last index of a steady interval
    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (rst)
        $stable(last_idx) |-> (phase_q <= last_idx));

    // R4: the last index is followed by phase zero
    assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == last_idx) && $stable(last_idx)) |=> (phase_q == '0));

endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
    import coin_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel_a,
    input  logic [1:0] ratio_sel_c,
    output logic       sync_n
);

    phase_t     last_idx;
    ctr_state_t st;
    logic       sync_n_q;

    coin_sync_period_lut u_lut (
        .sel_a    (sel_t'(ratio_sel_a)),
        .sel_c    (sel_t'(ratio_sel_c)),
        .last_idx (last_idx)
    );

    coin_sync_phase_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .last_idx (last_idx),
        .st       (st)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sync_n_q <= 1'b1;
        else
            sync_n_q <= ~st.next_at_last;
    end

    assign sync_n = sync_n_q;

    // R1: reset forces the line high
    assert_reset_high_R1: assert property (@(posedge clk)
        rst |=> sync_n);

    // R6: a low pulse is one cycle wide
    assert_single_low_R6: assert property (@(posedge clk) disable iff (rst)
        !sync_n |=> sync_n);

    // R5: the edge ending a pulse is phase zero
    assert_low_before_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !sync_n |=> (st.phase == '0));

endmodule

// File: tb/tb_coin_sync_gen.sv
module tb_coin_sync_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sa  = 2'd0;
    logic [1:0] sc  = 2'd0;
    logic       sync_n;

    always #5 clk = ~clk;

    coin_sync_gen dut (
        .clk         (clk),
        .rst         (rst),
        .ratio_sel_a (sa),
        .ratio_sel_c (sc),
        .sync_n      (sync_n)
    );

    int checks   = 0;
    int fails    = 0;
    int k        = 0;
    int per      = 4;
    int da       = 4;
    int dc       = 2;
    int last_low = -1;
    int cyc      = 0;
    bit done     = 1'b0;

    function automatic int ref_a(input int s);
        int v[4] = '{4, 6, 8, 12};
        return v[s];
    endfunction

    function automatic int ref_c(input int s);
        int v[4] = '{2, 4, 6, 8};
        return v[s];
    endfunction

    function automatic int ref_lcm(input int x, input int y);
        int m = x;
        while (m % y != 0) m += x;
        return m;
    endfunction

    task automatic check(input logic act, input logic expv, input string tag, input int edge_n);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: sync_n=%b expected %b (sel_a=%0d sel_c=%0d edge %0d)",
                     tag, act, expv, sa, sc, edge_n);
        end
    endtask

    task automatic step();
        logic  expv;
        string tag;
        int    kk;
        @(posedge clk);
        if (rst) begin
            k = 0;
            kk = -1;
            last_low = -1;
            expv = 1'b1;
            tag = "R1";
        end else begin
            kk = k;
            expv = ((k % per) == per - 1) ? 1'b0 : 1'b1;
            if (expv == 1'b0)
                tag = (kk == per - 1) ? "R5" : ((da == dc) ? "R7" : "R6");
            else
                tag = (da == dc) ? "R7" : "R4";
            k++;
        end
        @(negedge clk);
        check(sync_n, expv, tag, kk);
        if (!rst && sync_n === 1'b0) begin
            checks++;
            if (last_low >= 0) begin
                if (kk - last_low != per) begin
                    fails++;
                    $display("FAIL R4: pulse interval=%0d expected %0d", kk - last_low, per);
                end
            end else if (kk != per - 1) begin
                fails++;
                $display("FAIL R2/R3: first pulse after edge %0d expected %0d", kk, per - 1);
            end
            last_low = kk;
        end
    endtask

    task automatic run_cfg(input int a, input int c, input int n);
        sa  = 2'(a);
        sc  = 2'(c);
        rst = 1'b1;
        da  = ref_a(a);
        dc  = ref_c(c);
        per = ref_lcm(da, dc);
        repeat (3) step();
        rst = 1'b0;
        repeat (n) step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL R4 watchdog: cycles=%0d expected below 50000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 4; c++) begin
                run_cfg(a, c, 3 * ref_lcm(ref_a(a), ref_c(c)) + 2);
            end
        end
        // R1 and R5: reset in mid-interval, then realign from a new edge 0
        run_cfg(3, 0, 17);
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        repeat (40) step();
        // R7: equal divisors once more after a long run
        run_cfg(2, 3, 50);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule